// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM organised as 16-bit words. It has a chip select, a serial clock and a data line toward the part, plus one data line back from it. A host issues one command at a time on a small request port. Four commands exist: read a word, write a word, enable writes and disable writes. Each request carries an 8-bit word address and 16 bits of write data. When the command finishes the block gives a one-cycle done pulse, the read word and an error flag.

Each command is built as a list of steps: deselect gaps, serial frames sent MSB first, a 16-bit read-back and a ready poll. A write runs as one self-timed sequence. The block enables writes, sends the 27-bit write frame, deselects and reselects the part, and then polls the returned data line until it reads high or a host-supplied poll limit runs out. It then disables writes again. Bit timing comes from a clock-enable divider. One delay interval lasts DIV clock cycles, and every pin phase holds for exactly one interval.

Top module: `mw_eeprom_master`

## Requirements
- R1: A request (req_valid high) is accepted only while busy is low; requests made while busy is high are ignored. busy is high from the cycle after acceptance until the cycle of done. done is a single-cycle pulse during which busy is low.
- R2: A read (req_op 0) sends an 11-bit frame MSB first: start bit 1, opcode 2'b10, then the 8 address bits. It then clocks in 16 data bits MSB first and presents them on rdata with done.
- R3: A write (req_op 1) sends these in order, each followed by a deselect: the write-enable frame, then a 27-bit frame (start 1, opcode 2'b01, 8 address bits, 16 data bits, MSB first), then a ready poll, then the write-disable frame.
- R4: The write-enable command (req_op 2) sends the 11-bit frame 1,0,0 followed by eight 1 bits (value 11'h4FF), then deselects.
- R5: The write-disable command (req_op 3) sends the 11-bit frame 1 followed by ten 0 bits (value 11'h400), then deselects.
- R6: Each sent bit takes three intervals with chip select high: clock low with the data set up, clock high, clock low. The data line never changes while the clock is high, and the clock is high only while chip select is high.
- R7: Each read bit is sampled at the end of an interval in which the clock is high. The sampled bit is shifted into the LSB of the word being assembled.
- R8: During the ready poll chip select is high and the clock low. The returned data line is sampled once per interval. The first high sample ends the poll with error 0. When poll_limit low samples have been taken (a limit of 0 acts as 1), the poll ends with error 1, and the deselect and write-disable frame still follow. Chip select stays high for poll_limit*DIV+1 cycles in a poll that times out.
- R9: Chip select is low for at least one interval before the first frame of a command, between any two frames, and after the last one. While the block is idle, chip select and clock are low.
- R10: One interval is DIV clock cycles: every clock-high phase lasts exactly DIV cycles.
- R11: rdata changes only with done at the end of a read. error changes only when a request is accepted (cleared) or with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request, taken when idle |
| req_op | input | 2 | 0 read, 1 write, 2 write enable, 3 write disable |
| req_addr | input | 8 | Word address |
| req_wdata | input | 16 | Word to write |
| poll_limit | input | POLL_W | Maximum ready samples for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last write timed out waiting for ready |
| rdata | output | 16 | Word returned by the last read |
| mw_cs | output | 1 | Chip select to the EEPROM |
| mw_sk | output | 1 | Serial clock to the EEPROM |
| mw_mosi | output | 1 | Serial data to the EEPROM |
| mw_miso | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The assertions check the pin discipline on every cycle: the clock only under chip select, the data held while the clock is high, a clock-high width of exactly DIV cycles, chip select falling only with the clock low, and quiet pins when idle. They also check the busy/done handshake and that rdata and error move only at the allowed moments. Only the bench scenarios can show what the frames contain, that read words come back intact, and the order of the enable, write, poll and disable steps. The same goes for the exact length of a timed-out poll, for the deselect gap lengths seen by an EEPROM model, and for commands that are ignored while busy.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = 16;
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + WORD_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WREN  = 2'd2,
    OP_WRDIS = 2'd3
  } mw_op_e;

  typedef enum logic [2:0] {
    ST_GAP  = 3'd0,
    ST_TX   = 3'd1,
    ST_RX   = 3'd2,
    ST_POLL = 3'd3,
    ST_END  = 3'd4
  } mw_step_e;

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [1:0] opc,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic [WORD_W-1:0] d);
    return {1'b1, opc, a, d};
  endfunction
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mw_bit_engine.sv
module mw_bit_engine
  import mw_pkg::*;
#(
  parameter int POLL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               go,
  input  mw_step_e           go_kind,
  input  logic [FRAME_W-1:0] go_frame,
  input  logic [LEN_W-1:0]   go_len,
  input  logic [POLL_W-1:0]  poll_lim,
  input  logic               miso,
  output logic               active,
  output logic               step_done,
  output logic               poll_timeout,
  output logic [WORD_W-1:0]  rx_word,
  output logic               cs,
  output logic               sk,
  output logic               mosi
);
  mw_step_e           kind;
  logic [1:0]         ph;
  logic [LEN_W-1:0]   bitn;
  logic [LEN_W-1:0]   len_q;
  logic [FRAME_W-1:0] sr;
  logic [POLL_W-1:0]  pcnt;
  logic               tx_last;
  logic               rx_last;
  logic               poll_full;

  assign tx_last   = (bitn == len_q - 1'b1);
  assign rx_last   = (bitn == LEN_W'(WORD_W - 1));
  assign poll_full = ({1'b0, pcnt} + 1'b1) >= {1'b0, poll_lim};

  always_comb begin
    step_done = 1'b0;
    if (active && tick) begin
      unique case (kind)
        ST_GAP:  step_done = 1'b1;
        ST_TX:   step_done = (ph == 2'd2) && tx_last;
        ST_RX:   step_done = (ph == 2'd1) && rx_last;
        ST_POLL: step_done = miso || poll_full;
        default: step_done = 1'b1;
      endcase
    end
  end

  assign poll_timeout = active && tick && (kind == ST_POLL) && !miso && poll_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      kind    <= ST_GAP;
      ph      <= 2'd0;
      bitn    <= '0;
      len_q   <= '0;
      sr      <= '0;
      pcnt    <= '0;
      rx_word <= '0;
      cs      <= 1'b0;
      sk      <= 1'b0;
      mosi    <= 1'b0;
    end else if (go) begin
      active <= 1'b1;
      kind   <= go_kind;
      ph     <= 2'd0;
      bitn   <= '0;
      len_q  <= go_len;
      sr     <= go_frame;
      pcnt   <= '0;
      unique case (go_kind)
        ST_GAP: begin
          cs   <= 1'b0;
          sk   <= 1'b0;
          mosi <= 1'b0;
        end
        ST_TX: begin
          cs   <= 1'b1;
          sk   <= 1'b0;
          mosi <= go_frame[FRAME_W-1];
        end
        ST_RX: begin
          cs <= 1'b1;
          sk <= 1'b1;
        end
        default: begin
          cs   <= 1'b1;
          sk   <= 1'b0;
          mosi <= 1'b0;
        end
      endcase
    end else if (active && tick) begin
      unique case (kind)
        ST_GAP: active <= 1'b0;
        ST_TX: begin
          unique case (ph)
            2'd0: begin
              ph <= 2'd1;
              sk <= 1'b1;
            end
            2'd1: begin
              ph <= 2'd2;
              sk <= 1'b0;
            end
            default: begin
              if (tx_last) begin
                active <= 1'b0;
              end else begin
                bitn <= bitn + 1'b1;
                ph   <= 2'd0;
                sr   <= sr << 1;
                mosi <= sr[FRAME_W-2];
              end
            end
          endcase
        end
        ST_RX: begin
          if (ph == 2'd0) begin
            rx_word <= {rx_word[WORD_W-2:0], miso};
            ph      <= 2'd1;
            sk      <= 1'b0;
          end else if (rx_last) begin
            active <= 1'b0;
          end else begin
            bitn <= bitn + 1'b1;
            ph   <= 2'd0;
            sk   <= 1'b1;
          end
        end
        ST_POLL: begin
          if (miso || poll_full) begin
            active <= 1'b0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: active <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mw_step_seq.sv
module mw_step_seq
  import mw_pkg::*;
#(
  parameter int POLL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  input  logic [POLL_W-1:0]  req_poll_limit,
  input  logic               eng_active,
  input  logic               step_done,
  input  logic               poll_timeout,
  input  logic [WORD_W-1:0]  rx_word,
  output logic               go,
  output mw_step_e           go_kind,
  output logic [FRAME_W-1:0] go_frame,
  output logic [LEN_W-1:0]   go_len,
  output logic [POLL_W-1:0]  poll_lim,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [WORD_W-1:0]  rdata
);
  localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(HDR_W);
  localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(FRAME_W);

  logic [3:0]        idx;
  mw_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              err_pend;

  logic [FRAME_W-1:0] f_en, f_dis, f_rd, f_wr;

  assign f_en  = mk_frame(2'b00, {2'b11, {(ADDR_W-2){1'b1}}}, '0);
  assign f_dis = mk_frame(2'b00, '0, '0);
  assign f_rd  = mk_frame(2'b10, addr_q, '0);
  assign f_wr  = mk_frame(2'b01, addr_q, data_q);

  always_comb begin
    go_kind  = ST_END;
    go_frame = '0;
    go_len   = SHORT_LEN;
    unique case (op_q)
      OP_READ: begin
        unique case (idx)
          4'd0, 4'd3: go_kind = ST_GAP;
          4'd1: begin go_kind = ST_TX; go_frame = f_rd; end
          4'd2: go_kind = ST_RX;
          default: go_kind = ST_END;
        endcase
      end
      OP_WRITE: begin
        unique case (idx)
          4'd0, 4'd2, 4'd4, 4'd6, 4'd8: go_kind = ST_GAP;
          4'd1: begin go_kind = ST_TX; go_frame = f_en; end
          4'd3: begin go_kind = ST_TX; go_frame = f_wr; go_len = LONG_LEN; end
          4'd5: go_kind = ST_POLL;
          4'd7: begin go_kind = ST_TX; go_frame = f_dis; end
          default: go_kind = ST_END;
        endcase
      end
      default: begin
        unique case (idx)
          4'd0, 4'd2: go_kind = ST_GAP;
          4'd1: begin
            go_kind  = ST_TX;
            go_frame = (op_q == OP_WREN) ? f_en : f_dis;
          end
          default: go_kind = ST_END;
        endcase
      end
    endcase
  end

  assign go = busy && !eng_active && (go_kind != ST_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      op_q     <= OP_READ;
      addr_q   <= '0;
      data_q   <= '0;
      poll_lim <= '0;
      err_pend <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy     <= 1'b1;
          op_q     <= mw_op_e'(req_op);
          addr_q   <= req_addr;
          data_q   <= req_wdata;
          poll_lim <= req_poll_limit;
          idx      <= '0;
          err_pend <= 1'b0;
          error    <= 1'b0;
        end
      end else begin
        if (step_done) begin
          idx <= idx + 1'b1;
        end
        if (poll_timeout) begin
          err_pend <= 1'b1;
        end
        if (go_kind == ST_END && !eng_active) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          error <= err_pend;
          if (op_q == OP_READ) begin
            rdata <= rx_word;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [WORD_W-1:0] rdata,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_mosi,
  input  logic              mw_miso
);
  logic               tick;
  logic               go;
  mw_step_e           go_kind;
  logic [FRAME_W-1:0] go_frame;
  logic [LEN_W-1:0]   go_len;
  logic [POLL_W-1:0]  poll_lim;
  logic               eng_active;
  logic               step_done;
  logic               poll_timeout;
  logic [WORD_W-1:0]  rx_word;

  mw_tick_gen #(.DIV(DIV)) tick_i (
    .clk     (clk),
    .rst     (rst),
    .restart (go),
    .tick    (tick)
  );

  mw_step_seq #(.POLL_W(POLL_W)) seq_i (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .req_poll_limit (poll_limit),
    .eng_active     (eng_active),
    .step_done      (step_done),
    .poll_timeout   (poll_timeout),
    .rx_word        (rx_word),
    .go             (go),
    .go_kind        (go_kind),
    .go_frame       (go_frame),
    .go_len         (go_len),
    .poll_lim       (poll_lim),
    .busy           (busy),
    .done           (done),
    .error          (error),
    .rdata          (rdata)
  );

  mw_bit_engine #(.POLL_W(POLL_W)) eng_i (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .go           (go),
    .go_kind      (go_kind),
    .go_frame     (go_frame),
    .go_len       (go_len),
    .poll_lim     (poll_lim),
    .miso         (mw_miso),
    .active       (eng_active),
    .step_done    (step_done),
    .poll_timeout (poll_timeout),
    .rx_word      (rx_word),
    .cs           (mw_cs),
    .sk           (mw_sk),
    .mosi         (mw_mosi)
  );
endmodule

// File: rtl/mw_eeprom_master_chk.sv
module mw_eeprom_master_chk #(
  parameter int DIV    = 4,
  parameter int POLL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [15:0]       rdata,
  input logic              mw_cs,
  input logic              mw_sk,
  input logic              mw_mosi,
  input logic [POLL_W-1:0] poll_limit
);
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !mw_sk) hi_cnt <= 0;
    else               hi_cnt <= hi_cnt + 1;
  end

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  assert_sk_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
    mw_sk |-> mw_cs);

  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    mw_sk |-> $stable(mw_mosi));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mw_cs && !mw_sk));

  assert_cs_fall_low_clk_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(mw_cs) |-> !$past(mw_sk));

  assert_sk_width_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(mw_sk) |-> (hi_cnt == DIV));

  assert_rdata_at_done_R11: assert property (@(posedge clk) disable iff (rst)
    (rdata != $past(rdata)) |-> done);

  assert_error_moves_R11: assert property (@(posedge clk) disable iff (rst)
    (error != $past(error)) |-> (done || $rose(busy)));

  logic unused_ok;
  assign unused_ok = ^poll_limit;
endmodule

bind mw_eeprom_master mw_eeprom_master_chk #(.DIV(DIV), .POLL_W(POLL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .error      (error),
  .rdata      (rdata),
  .mw_cs      (mw_cs),
  .mw_sk      (mw_sk),
  .mw_mosi    (mw_mosi),
  .poll_limit (poll_limit)
);

// File: tb/mw_eeprom_master_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_master_tb_top;
  localparam int DIV    = 4;
  localparam int POLL_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic [POLL_W-1:0] poll_limit = '0;
  logic busy, done, error;
  logic [15:0] rdata;
  logic mw_cs, mw_sk, mw_mosi, mw_miso;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  mw_eeprom_master #(.DIV(DIV), .POLL_W(POLL_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .poll_limit(poll_limit),
    .busy(busy), .done(done), .error(error), .rdata(rdata),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_mosi(mw_mosi), .mw_miso(mw_miso)
  );

  // EEPROM model
  logic [15:0] mem [0:255];
  logic        prev_cs = 1'b0, prev_sk = 1'b0;
  int          bitcnt = 0;
  logic [26:0] shreg = '0;
  logic        rd_mode = 1'b0, rd_bit = 1'b0;
  logic [15:0] rd_word = '0;
  logic        wr_en = 1'b0;
  int          busy_left = 0, busy_cycles = 20;
  int          lo_cnt = 1000, hi_cnt = 0, skh = 0;
  int          n_ewen = 0, n_ewds = 0, n_wr = 0, n_rd = 0;
  int          gap_viol = 0, skw_viol = 0;
  int          last_len = 0, last_poll_len = 0;
  logic [26:0] last_frame = '0, last_wr_frame = '0;
  logic [7:0]  last_rd_addr = '0;

  assign mw_miso = rd_mode ? rd_bit : (busy_left == 0);

  always @(posedge clk) begin
    logic [26:0] nb;
    nb = {shreg[25:0], mw_mosi};
    prev_cs <= mw_cs;
    prev_sk <= mw_sk;
    if (busy_left > 0) busy_left <= busy_left - 1;
    if (mw_cs) hi_cnt <= hi_cnt + 1;
    else       lo_cnt <= lo_cnt + 1;
    if (mw_sk) skh <= skh + 1;
    if (!mw_sk && prev_sk) begin
      if (skh != DIV) skw_viol <= skw_viol + 1;
      skh <= 0;
    end
    if (mw_cs && !prev_cs) begin
      bitcnt  <= 0;
      shreg   <= '0;
      rd_mode <= 1'b0;
      hi_cnt  <= 1;
      if (lo_cnt < DIV) gap_viol <= gap_viol + 1;
    end
    if (!mw_cs && prev_cs) begin
      lo_cnt     <= 1;
      last_len   <= bitcnt;
      last_frame <= shreg;
      rd_mode    <= 1'b0;
      if (bitcnt == 0) last_poll_len <= hi_cnt;
      if (bitcnt == 11 && shreg[10:8] == 3'b100) begin
        if (shreg[7:6] == 2'b11) begin wr_en <= 1'b1; n_ewen <= n_ewen + 1; end
        if (shreg[7:6] == 2'b00) begin wr_en <= 1'b0; n_ewds <= n_ewds + 1; end
      end
      if (bitcnt == 27 && shreg[26:24] == 3'b101) begin
        n_wr          <= n_wr + 1;
        last_wr_frame <= shreg;
        if (wr_en) mem[shreg[23:16]] <= shreg[15:0];
        busy_left <= busy_cycles;
      end
    end
    if (mw_cs && prev_cs && mw_sk && !prev_sk) begin
      if (rd_mode) begin
        rd_bit  <= rd_word[15];
        rd_word <= rd_word << 1;
      end else begin
        shreg  <= nb;
        bitcnt <= bitcnt + 1;
        if (bitcnt == 10 && nb[10:8] == 3'b110) begin
          rd_mode      <= 1'b1;
          rd_word      <= mem[nb[7:0]];
          n_rd         <= n_rd + 1;
          last_rd_addr <= nb[7:0];
        end
      end
    end
  end

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0101) ^ 16'hA5C3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a,
                         input logic [15:0] d, input logic [POLL_W-1:0] lim);
    int guard;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; poll_limit = lim;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", busy, 1);
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk("R1 done reached", done, 1);
    chk("R1 busy low with done", busy, 0);
    @(negedge clk);
    chk("R1 done single pulse", done, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R11 reset error", error, 0);
    chk("R11 reset rdata", rdata, 0);
    chk("R9 reset cs", mw_cs, 0);
    chk("R9 reset sk", mw_sk, 0);
  endtask

  task automatic t_read(input logic [7:0] a);
    int r0;
    r0 = n_rd;
    run_cmd(2'd0, a, 16'h0, 8'd4);
    chk("R2 read frame seen", n_rd, r0 + 1);
    chk("R2 read address", last_rd_addr, a);
    chk("R7 read data", rdata, mem[a]);
    chk("R9 read gaps", gap_viol, 0);
  endtask

  task automatic t_wren_wrdis;
    int e0, d0;
    logic [15:0] keep;
    e0 = n_ewen; d0 = n_ewds; keep = rdata;
    run_cmd(2'd2, 8'h12, 16'h0, 8'd4);
    chk("R4 enable count", n_ewen, e0 + 1);
    chk("R4 enable frame len", last_len, 11);
    chk("R4 enable frame", last_frame, 27'h4FF);
    chk("R11 rdata held", rdata, keep);
    run_cmd(2'd3, 8'hFF, 16'h0, 8'd4);
    chk("R5 disable count", n_ewds, d0 + 1);
    chk("R5 disable frame", last_frame, 27'h400);
  endtask

  task automatic t_write_ok(input logic [7:0] a, input logic [15:0] d);
    int e0, d0, w0;
    e0 = n_ewen; d0 = n_ewds; w0 = n_wr;
    busy_cycles = 30;
    run_cmd(2'd1, a, d, 8'd200);
    chk("R3 write frame count", n_wr, w0 + 1);
    chk("R3 enable before write", n_ewen, e0 + 1);
    chk("R3 disable after write", n_ewds, d0 + 1);
    chk("R3 write frame", last_wr_frame, {3'b101, a, d});
    chk("R3 final frame is disable", last_frame, 27'h400);
    chk("R8 no error on ready", error, 0);
    chk("R8 poll ended early", (last_poll_len > DIV && last_poll_len < 200 * DIV + 1), 1);
    t_read(a);
    chk("R3 readback", rdata, d);
  endtask

  task automatic t_write_timeout(input logic [POLL_W-1:0] lim, input int exp_len);
    int d0;
    d0 = n_ewds;
    busy_cycles = 100000;
    run_cmd(2'd1, 8'h44, 16'h1357, lim);
    chk("R8 timeout error", error, 1);
    chk("R8 timeout poll length", last_poll_len, exp_len);
    chk("R8 disable still sent", n_ewds, d0 + 1);
    chk("R8 final frame disable", last_frame, 27'h400);
  endtask

  task automatic t_busy_ignore;
    int w0, e0, guard;
    w0 = n_wr; e0 = n_ewen;
    @(negedge clk);
    req_op = 2'd0; req_addr = 8'h07; poll_limit = 8'd4; req_valid = 1'b1;
    @(negedge clk);
    req_op = 2'd1; req_addr = 8'h08; req_wdata = 16'hDEAD;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    chk("R1 read done while flooded", done, 1);
    chk("R1 ignored write frame", n_wr, w0);
    chk("R1 ignored enable frame", n_ewen, e0);
    chk("R1 read data intact", rdata, mem[8'h07]);
    repeat (2) @(negedge clk);
    chk("R1 no second command", busy, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(8'h00);
    t_read(8'hFF);
    t_read(8'h5A);
    t_wren_wrdis();
    t_write_ok(8'h33, 16'hBEEF);
    t_write_timeout(8'd5, 5 * DIV + 1);
    t_write_timeout(8'd0, DIV + 1);
    run_cmd(2'd2, 8'h00, 16'h0, 8'd4);
    chk("R11 error cleared by next command", error, 0);
    t_busy_ignore();
    chk("R9 gap violations", gap_viol, 0);
    chk("R10 clock high width", skw_viol, 0);
    chk("R6 clock low at end", mw_sk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule